// File: doc/BRIEF.md
# Segmented Carry-Save Accumulator Adder

This block is a wide accumulator built for long shift-and-add arithmetic, where a full-width carry chain would be too slow. The datapath is cut into fixed segments. A carry ripples only inside one segment. The carry leaving a segment is captured in a flip-flop and enters the segment above it on the next operation. Between additions the accumulated value therefore sits in a partly redundant form: a sum word together with one saved carry bit per segment boundary.

A caller drives one command per clock. The commands are: clear, add an operand, resolve, realign-and-shift, and hold. Resolve folds the saved carries back into the sum and saves the new segment carries. Repeated resolve passes give a plain binary result, and the all-carries-zero flag shows when that point is reached. A left shift would misalign the saved carries, so realign-and-shift makes a resolve pass whenever carries are still pending. It doubles the sum only once no carry is outstanding. The carry leaving the top segment, and any bit shifted out of the top, is gathered into a sticky overflow bit and is never fed back. Deciding when a modular reduction is needed is left to the caller.

Top module: `seg_csa_accum`

## Requirements
- R1: While reset is asserted and on the first cycle after it, sumOut is zero, carriesZero is 1 and overflow is 0.
- R2: Command opSel=1 (clear) sets the sum, all saved carries and overflow to zero on the next edge.
- R3: Command opSel=2 (add) adds operandIn segment by segment (segment width SEG_W, segment k = bits k*SEG_W upward). Each segment adds its own sum bits, its operand bits and the carry saved from segment k-1. The carry out of segment k is saved for the next command and does not reach segment k+1 in the same cycle.
- R4: The sum word plus every saved carry, each weighted by 2^(SEG_W*(k+1)), always equals the true accumulated value modulo 2^W. After the carries are resolved, sumOut equals that value.
- R5: Command opSel=4 (resolve) behaves as an add of a zero operand. When no carry is pending it leaves the sum unchanged.
- R6: Command opSel=3 (realign-and-shift) issued while carriesZero is 0 makes one resolve pass and does not shift.
- R7: Command opSel=3 issued while carriesZero is 1 shifts the sum left by one bit and puts 0 in bit 0.
- R8: overflow is set by a carry out of the top segment or by a 1 shifted out of bit W-1. Once set, it stays set until a clear or a reset.
- R9: From any state, at most NSEG-1 consecutive resolve commands bring carriesZero to 1, where NSEG = W/SEG_W.
- R10: opSel=0 and opSel values 5 to 7 change no state, whatever value operandIn has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opSel | input | 3 | Command: 0 hold, 1 clear, 2 add, 3 realign-and-shift, 4 resolve, 5-7 hold |
| operandIn | input | W | Operand used by the add command |
| sumOut | output | W | Sum word of the accumulator (redundant while carries are pending) |
| carriesZero | output | 1 | High when no saved segment carry is pending |
| overflow | output | 1 | Sticky overflow out of the top of the word |

## Verification
The bench builds the block with W=32 and SEG_W=8, which gives four segments and three saved carries. With this size a carry that starts at the bottom and crosses every boundary needs exactly NSEG-1 resolve passes, so the worst-case bound of R9 is reached. Top-segment overflow is also easy to produce with a few adds. The 32-bit width lets the bench track the true accumulated value as a plain integer. It compares that value against the resolved sum after mixed sequences of adds, realign-and-shift commands and partial resolves.

// File: rtl/seg_csa_pkg.sv
package seg_csa_pkg;

  localparam logic [2:0] OP_HOLD    = 3'd0;
  localparam logic [2:0] OP_CLEAR   = 3'd1;
  localparam logic [2:0] OP_ADD     = 3'd2;
  localparam logic [2:0] OP_SHIFT   = 3'd3;
  localparam logic [2:0] OP_RESOLVE = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;         // zero all state
    logic pass;        // segment add pass (operand or zero)
    logic takeOperand; // operand path selected in the wide mux
    logic shift;       // left shift by one
  } dpStrobes_t;

endpackage

// File: rtl/seg_csa_segment.sv
module seg_csa_segment #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] aIn,
  input  logic [SEG_W-1:0] bIn,
  input  logic             cIn,
  output logic [SEG_W-1:0] sOut,
  output logic             cOut
);
  logic [SEG_W:0] total;

  always_comb begin
    total = {1'b0, aIn} + {1'b0, bIn} + {{SEG_W{1'b0}}, cIn};
    sOut  = total[SEG_W-1:0];
    cOut  = total[SEG_W];
  end
endmodule

// File: rtl/seg_csa_ctrl.sv
module seg_csa_ctrl
  import seg_csa_pkg::*;
(
  input  logic       [2:0] opSel,
  input  logic             carriesZero,
  output dpStrobes_t       strb
);
  always_comb begin
    strb = '0;
    unique case (opSel)
      OP_CLEAR:   strb.clr = 1'b1;
      OP_ADD: begin
        strb.pass        = 1'b1;
        strb.takeOperand = 1'b1;
      end
      OP_RESOLVE: strb.pass = 1'b1;
      OP_SHIFT: begin
        // realign first; shift only once nothing is pending
        if (carriesZero) strb.shift = 1'b1;
        else             strb.pass  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/seg_csa_dp.sv
module seg_csa_dp
  import seg_csa_pkg::*;
#(
  parameter int W     = 512,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strb,
  input  logic [W-1:0]     operandIn,
  output logic [W-1:0]     sumQ,
  output logic             carriesZero,
  output logic             ovfQ
);
  localparam int NSEG = W / SEG_W;
  localparam int CW   = NSEG - 1;

  logic [CW-1:0]   carryQ;
  logic [W-1:0]    addend;
  logic [W-1:0]    passSum;
  logic [NSEG-1:0] segCin;
  logic [NSEG-1:0] segCout;

  // wide mux: operand path or zero (carry realignment path)
  assign addend = strb.takeOperand ? operandIn : '0;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    if (k == 0) begin : g_lo
      assign segCin[k] = 1'b0;
    end else begin : g_hi
      assign segCin[k] = carryQ[k-1];
    end
    seg_csa_segment #(.SEG_W(SEG_W)) seg_i (
      .aIn  (sumQ[k*SEG_W +: SEG_W]),
      .bIn  (addend[k*SEG_W +: SEG_W]),
      .cIn  (segCin[k]),
      .sOut (passSum[k*SEG_W +: SEG_W]),
      .cOut (segCout[k])
    );
  end

  assign carriesZero = ~|carryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ   <= '0;
      carryQ <= '0;
      ovfQ   <= 1'b0;
    end else if (strb.clr) begin
      sumQ   <= '0;
      carryQ <= '0;
      ovfQ   <= 1'b0;
    end else if (strb.pass) begin
      sumQ   <= passSum;
      carryQ <= segCout[CW-1:0];
      ovfQ   <= ovfQ | segCout[NSEG-1];
    end else if (strb.shift) begin
      sumQ   <= {sumQ[W-2:0], 1'b0};
      ovfQ   <= ovfQ | sumQ[W-1];
    end
  end
endmodule

// File: rtl/seg_csa_accum.sv
module seg_csa_accum
  import seg_csa_pkg::*;
#(
  parameter int W     = 512,
  parameter int SEG_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   opSel,
  input  logic [W-1:0] operandIn,
  output logic [W-1:0] sumOut,
  output logic         carriesZero,
  output logic         overflow
);
  dpStrobes_t strb;

  seg_csa_ctrl ctrl_i (
    .opSel       (opSel),
    .carriesZero (carriesZero),
    .strb        (strb)
  );

  seg_csa_dp #(.W(W), .SEG_W(SEG_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .operandIn   (operandIn),
    .sumQ        (sumOut),
    .carriesZero (carriesZero),
    .ovfQ        (overflow)
  );
endmodule

// File: rtl/seg_csa_accum_chk.sv
module seg_csa_accum_chk
  import seg_csa_pkg::*;
#(
  parameter int W     = 512,
  parameter int SEG_W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [2:0]   opSel,
  input logic [W-1:0] sumOut,
  input logic         carriesZero,
  input logic         overflow
);
  localparam int NSEG  = W / SEG_W;
  localparam int RUN_W = $clog2(NSEG) + 2;

  logic [RUN_W-1:0] resolveRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        resolveRun <= '0;
    else if (opSel != OP_RESOLVE)     resolveRun <= '0;
    else if (resolveRun < RUN_W'(NSEG)) resolveRun <= resolveRun + 1'b1;
  end

  // R2
  clear_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    opSel == OP_CLEAR |=> (sumOut == '0) && carriesZero && !overflow);

  // R7
  shift_when_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_SHIFT && carriesZero) |=> sumOut == ($past(sumOut) << 1));

  // R5
  resolve_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_RESOLVE && carriesZero) |=> $stable(sumOut) && carriesZero);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && opSel != OP_CLEAR) |=> overflow);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_HOLD || opSel > OP_RESOLVE)
      |=> $stable(sumOut) && $stable(carriesZero) && $stable(overflow));

  // R9
  resolve_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    resolveRun >= RUN_W'(NSEG - 1) |-> carriesZero);

endmodule

bind seg_csa_accum seg_csa_accum_chk #(.W(W), .SEG_W(SEG_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .opSel       (opSel),
  .sumOut      (sumOut),
  .carriesZero (carriesZero),
  .overflow    (overflow)
);

// File: tb/seg_csa_accum_tb_top.sv
module seg_csa_accum_tb_top;
  import seg_csa_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int SEG        = 8;
  localparam int NSEG       = W / SEG;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   opSel = OP_HOLD;
  logic [W-1:0] operandIn = '0;
  logic [W-1:0] sumOut;
  logic         carriesZero;
  logic         overflow;

  int testsRun = 0;
  int testsFailed = 0;

  // behavioural reference state
  logic [W-1:0]      mSum = '0;
  logic [NSEG-2:0]   mCar = '0;
  logic              mOvf = 1'b0;
  logic [W-1:0]      mTrue = '0;
  logic [31:0]       rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_csa_accum #(.W(W), .SEG_W(SEG)) dut_i (
    .clk(clk), .rstN(rstN), .opSel(opSel), .operandIn(operandIn),
    .sumOut(sumOut), .carriesZero(carriesZero), .overflow(overflow)
  );

  task automatic checkEq(string req, string what, longint act, longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    checkEq(req, "sumOut", longint'(sumOut), longint'(mSum));
    checkEq(req, "carriesZero", longint'(carriesZero), longint'(mCar == '0));
    checkEq(req, "overflow", longint'(overflow), longint'(mOvf));
  endtask

  task automatic modelPass(logic [W-1:0] addend);
    logic [W-1:0]    nSum;
    logic [NSEG-2:0] nCar;
    nSum = '0;
    nCar = '0;
    for (int k = 0; k < NSEG; k++) begin
      int s;
      s = int'(mSum[k*SEG +: SEG]) + int'(addend[k*SEG +: SEG]);
      if (k > 0) s = s + int'(mCar[k-1]);
      nSum[k*SEG +: SEG] = s[SEG-1:0];
      if (k < NSEG-1) nCar[k] = s[SEG];
      else if (s[SEG]) mOvf = 1'b1;
    end
    mSum  = nSum;
    mCar  = nCar;
    mTrue = mTrue + addend;
  endtask

  task automatic modelStep(logic [2:0] op, logic [W-1:0] opnd);
    case (op)
      OP_CLEAR: begin mSum = '0; mCar = '0; mOvf = 1'b0; mTrue = '0; end
      OP_ADD:     modelPass(opnd);
      OP_RESOLVE: modelPass('0);
      OP_SHIFT: begin
        if (mCar == '0) begin
          if (mSum[W-1]) mOvf = 1'b1;
          mSum  = mSum << 1;
          mTrue = mTrue << 1;
        end else modelPass('0);
      end
      default: ;
    endcase
  endtask

  // apply one command on the next edge, compare at the following negedge
  task automatic doOp(logic [2:0] op, logic [W-1:0] opnd, string req);
    opSel = op;
    operandIn = opnd;
    @(posedge clk);
    modelStep(op, opnd);
    @(negedge clk);
    compareAll(req);
  endtask

  task automatic resolveAll(string tag);
    int n = 0;
    while (!carriesZero && n < 2*NSEG) begin
      doOp(OP_RESOLVE, '0, "R5");
      n++;
    end
    // R9
    checkEq("R9", {"resolve passes bounded ", tag}, longint'(n <= NSEG-1), 1);
    // R4
    checkEq("R4", {"resolved value ", tag}, longint'(sumOut), longint'(mTrue));
  endtask

  function automatic logic [31:0] nextRng(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R3: carry saved at the segment boundary, not rippled across it
    doOp(OP_ADD, 32'h0000_00FF, "R3");
    doOp(OP_ADD, 32'h0000_0001, "R3");
    checkEq("R3", "sum after boundary carry", longint'(sumOut), 0);
    checkEq("R3", "carry pending", longint'(carriesZero), 0);
    doOp(OP_RESOLVE, '0, "R5");
    checkEq("R5", "carry folded in", longint'(sumOut), 32'h100);
    doOp(OP_RESOLVE, '0, "R5");

    // R9 worst case: carry crosses every boundary
    doOp(OP_CLEAR, '0, "R2");
    doOp(OP_ADD, 32'h00FF_FFFF, "R3");
    doOp(OP_ADD, 32'h0000_0001, "R3");
    resolveAll("full ripple");
    checkEq("R9", "full ripple value", longint'(sumOut), 32'h0100_0000);

    // R6 then R7: shift realigns first, then doubles
    doOp(OP_CLEAR, '0, "R2");
    doOp(OP_ADD, 32'h0000_80FF, "R3");
    doOp(OP_ADD, 32'h0000_0001, "R3");
    doOp(OP_SHIFT, '0, "R6");
    checkEq("R6", "realign not shift", longint'(sumOut), 32'h0000_8100);
    doOp(OP_SHIFT, '0, "R7");
    checkEq("R7", "shifted", longint'(sumOut), 32'h0001_0200);

    // R8: overflow from top segment carry and from the shifted-out bit
    doOp(OP_ADD, 32'h8000_0000, "R8");
    doOp(OP_ADD, 32'h8000_0000, "R8");
    checkEq("R8", "top carry sets overflow", longint'(overflow), 1);
    doOp(OP_ADD, 32'h0000_0001, "R8");
    checkEq("R8", "overflow stays set", longint'(overflow), 1);
    doOp(OP_CLEAR, '0, "R2");
    checkEq("R2", "clear drops overflow", longint'(overflow), 0);
    doOp(OP_ADD, 32'h8000_0000, "R8");
    doOp(OP_SHIFT, '0, "R8");
    checkEq("R8", "shift-out sets overflow", longint'(overflow), 1);

    // R10: hold and unused codes ignore operandIn
    doOp(OP_CLEAR, '0, "R2");
    doOp(OP_ADD, 32'h00FF_00FF, "R3");
    doOp(OP_ADD, 32'h0001_0001, "R3");
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c > 4) doOp(3'(c), 32'hFFFF_FFFF, "R10");
    end
    checkEq("R10", "carries kept over hold", longint'(carriesZero), 0);
    resolveAll("after holds");

    // mixed sequences against the true accumulated value
    for (int round = 0; round < 6; round++) begin
      doOp(OP_CLEAR, '0, "R2");
      for (int i = 0; i < 40; i++) begin
        rng = nextRng(rng);
        case (rng[2:0])
          3'd5:    doOp(OP_SHIFT, '0, "R6");
          3'd6:    doOp(OP_RESOLVE, '0, "R5");
          3'd7:    doOp(OP_HOLD, rng, "R10");
          default: doOp(OP_ADD, nextRng(rng), "R3");
        endcase
      end
      resolveAll("mixed");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule